// File: doc/BRIEF.md
# Preamble Standard Arbiter

Several correlators run side by side in a receiver. Each one matches the incoming samples against a different known preamble and reports a correlation metric with a valid flag. This block compares each metric with a threshold for that channel. It decides which standard, if any, is present. It then emits a single-cycle frame-start pulse that carries the identity of the winning channel.

The parameter set of the winning standard is driven out at the same time:
- packet length,
- symbol size,
- training period.

These values are not selected by fixed logic. They sit in a small register file that a processor loads through a simple write port. Thresholds and a hold-off interval are in the same register file.

Channel 0 carries the short (32-sample) preamble. Channels 1 and 2 carry long (64-sample) preambles. A long-preamble hit overrides a short one, because a long-preamble hit is less likely to be a false alarm.

A small state machine controls re-arming:
- **ST_ARMED** accepts detections.
- The transition **capture** moves to **ST_HOLD** when the hold-off count is non-zero.
- The transition **capture-and-stay** keeps the machine in ST_ARMED when the hold-off count is zero.
- In ST_HOLD, the transition **count** decrements a counter on each edge.
- The transition **release** returns to ST_ARMED on the edge where the counter reads one.

Top module: `preamble_std_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `frame_start` is 0, `det_id` is 0 and all three parameter outputs are 0. The threshold defaults are 50 for channel 0 and 100 for channels 1 and 2. The hold-off default is 0.
- R2: Channel k registers a hit on a clock edge only when `met_valid[k]` is 1 and its 8-bit metric `met_data[8k+7:8k]` is strictly greater than that channel's threshold. A metric equal to or below the threshold, or a metric with its valid flag low, produces no detection.
- R3: When channel 0 and at least one long channel (1 or 2) hit on the same edge, the winner is a long channel.
- R4: When both long channels hit on the same edge, channel 1 wins. Channel 0 wins only when it is the sole hit.
- R5: A detection accepted on an edge makes `frame_start` high for exactly the following cycle. In that cycle `det_id` holds the winner index, and `pkt_len`, `sym_size` and `train_len` hold the winner's registered parameters.
- R6: With hold-off value H, hits on the H clock edges that follow an accepted detection are ignored. The next edge after those H edges can detect again. With H = 0, detections on consecutive edges each produce a pulse.
- R7: `det_id` and the parameter outputs change only together with a frame-start pulse. Rewriting a parameter register does not change the outputs until the next detection of that standard.
- R8: Register map, written on a rising edge when `cfg_we` is 1:
  - address k (0 to 2) is the threshold of channel k, in `cfg_wdata[7:0]`;
  - address 3 is the hold-off count;
  - address 4+3k+f is field f of standard k, where f=0 is packet length, f=1 is symbol size and f=2 is training period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| met_valid | input | 3 | Per-channel metric valid flags, bit k for channel k |
| met_data | input | 24 | Packed 8-bit metrics, channel k in bits 8k+7:8k |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| frame_start | output | 1 | One-cycle detection pulse |
| det_id | output | 2 | Index of the winning channel |
| pkt_len | output | 16 | Packet length of the detected standard |
| sym_size | output | 16 | Symbol size of the detected standard |
| train_len | output | 16 | Training period of the detected standard |

## Verification
The hardest situation to reach is the hold-off window. In that window hits are present at the inputs and have to be dropped, and the machine has to re-arm on exactly the right edge. The stimulus reaches it by programming a hold-off of three and then holding a channel-0 hit for five consecutive edges. The expected pulse pattern on those five edges is 1, 0, 0, 0, 1. A hold-off of zero is then checked with two back-to-back hits. Output stability is reached by rewriting a parameter register while the outputs still show that standard, then confirming that the old value persists until a fresh detection.

// File: rtl/psa_pkg.sv
package psa_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_HOLD  = 1'b1
    } psa_state_t;

    localparam int FIELDS_PER_STD = 3;
    localparam int FLD_PKT        = 0;
    localparam int FLD_SYM        = 1;
    localparam int FLD_TRN        = 2;

endpackage

// File: rtl/psa_cfg_regs.sv
module psa_cfg_regs
    import psa_pkg::*;
#(
    parameter int                       NUM_CH   = 3,
    parameter int                       METRIC_W = 8,
    parameter int                       DATA_W   = 16,
    parameter int                       ADDR_W   = 4,
    parameter logic [NUM_CH*METRIC_W-1:0] THR_DEF = {8'd100, 8'd100, 8'd50},
    parameter logic [DATA_W-1:0]        HOLD_DEF = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [ADDR_W-1:0]                    cfg_addr,
    input  logic [DATA_W-1:0]                    cfg_wdata,
    output logic [NUM_CH*METRIC_W-1:0]           thr_flat,
    output logic [DATA_W-1:0]                    holdoff,
    output logic [NUM_CH*FIELDS_PER_STD*DATA_W-1:0] par_flat
);

    localparam int HOLD_ADDR = NUM_CH;
    localparam int PAR_BASE  = NUM_CH + 1;
    localparam int NUM_PAR   = NUM_CH * FIELDS_PER_STD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_flat <= THR_DEF;
            holdoff  <= HOLD_DEF;
            par_flat <= '0;
        end else if (cfg_we) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (cfg_addr == ADDR_W'(k)) begin
                    thr_flat[k*METRIC_W +: METRIC_W] <= cfg_wdata[METRIC_W-1:0];
                end
            end
            if (cfg_addr == ADDR_W'(HOLD_ADDR)) begin
                holdoff <= cfg_wdata;
            end
            for (int k = 0; k < NUM_PAR; k++) begin
                if (cfg_addr == ADDR_W'(PAR_BASE + k)) begin
                    par_flat[k*DATA_W +: DATA_W] <= cfg_wdata;
                end
            end
        end
    end

endmodule

// File: rtl/psa_hit_detect.sv
module psa_hit_detect #(
    parameter int NUM_CH   = 3,
    parameter int METRIC_W = 8
) (
    input  logic [NUM_CH-1:0]          met_valid,
    input  logic [NUM_CH*METRIC_W-1:0] met_data,
    input  logic [NUM_CH*METRIC_W-1:0] thr_flat,
    output logic [NUM_CH-1:0]          hit
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [METRIC_W-1:0] metric;
        logic [METRIC_W-1:0] limit;
        assign metric = met_data[g*METRIC_W +: METRIC_W];
        assign limit  = thr_flat[g*METRIC_W +: METRIC_W];
        // strictly above: an equal metric is treated as noise
        assign hit[g] = met_valid[g] && (metric > limit);
    end

endmodule

// File: rtl/psa_priority.sv
module psa_priority #(
    parameter int                NUM_CH    = 3,
    parameter int                ID_W      = 2,
    parameter logic [NUM_CH-1:0] LONG_MASK = 3'b110
) (
    input  logic [NUM_CH-1:0] hit,
    output logic              any_hit,
    output logic [ID_W-1:0]   win_id
);

    logic [NUM_CH-1:0] long_hit;
    logic [NUM_CH-1:0] pool;

    always_comb begin
        long_hit = hit & LONG_MASK;
        pool     = (long_hit != '0) ? long_hit : hit;
        win_id   = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (pool[k]) begin
                win_id = ID_W'(k);
            end
        end
        any_hit = |hit;
    end

endmodule

// File: rtl/preamble_std_arbiter.sv
module preamble_std_arbiter
    import psa_pkg::*;
#(
    parameter int                         NUM_CH    = 3,
    parameter int                         METRIC_W  = 8,
    parameter int                         DATA_W    = 16,
    parameter int                         ADDR_W    = 4,
    parameter int                         ID_W      = $clog2(NUM_CH),
    parameter logic [NUM_CH-1:0]          LONG_MASK = 3'b110,
    parameter logic [NUM_CH*METRIC_W-1:0] THR_DEF   = {8'd100, 8'd100, 8'd50},
    parameter logic [DATA_W-1:0]          HOLD_DEF  = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          met_valid,
    input  logic [NUM_CH*METRIC_W-1:0] met_data,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic                       frame_start,
    output logic [ID_W-1:0]            det_id,
    output logic [DATA_W-1:0]          pkt_len,
    output logic [DATA_W-1:0]          sym_size,
    output logic [DATA_W-1:0]          train_len
);

    localparam int STD_W = FIELDS_PER_STD * DATA_W;

    logic [NUM_CH*METRIC_W-1:0] thr_flat;
    logic [DATA_W-1:0]          holdoff;
    logic [NUM_CH*STD_W-1:0]    par_flat;
    logic [NUM_CH-1:0]          hit;
    logic                       any_hit;
    logic [ID_W-1:0]            win_id;
    psa_state_t                 state;
    psa_state_t                 state_nx;
    logic [DATA_W-1:0]          hold_cnt;
    logic                       capture;
    int                         sel_base;

    psa_cfg_regs #(
        .NUM_CH  (NUM_CH),
        .METRIC_W(METRIC_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .THR_DEF (THR_DEF),
        .HOLD_DEF(HOLD_DEF)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .thr_flat (thr_flat),
        .holdoff  (holdoff),
        .par_flat (par_flat)
    );

    psa_hit_detect #(
        .NUM_CH  (NUM_CH),
        .METRIC_W(METRIC_W)
    ) hits_i (
        .met_valid(met_valid),
        .met_data (met_data),
        .thr_flat (thr_flat),
        .hit      (hit)
    );

    psa_priority #(
        .NUM_CH   (NUM_CH),
        .ID_W     (ID_W),
        .LONG_MASK(LONG_MASK)
    ) prio_i (
        .hit    (hit),
        .any_hit(any_hit),
        .win_id (win_id)
    );

    assign capture  = (state == ST_ARMED) && any_hit;
    assign sel_base = int'(win_id) * STD_W;

    // transitions: capture, capture-and-stay, count, release
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: if (any_hit && (holdoff != '0)) state_nx = ST_HOLD;
            ST_HOLD:  if (hold_cnt == DATA_W'(1))     state_nx = ST_ARMED;
        endcase
    end

    // state register and hold-off counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_ARMED;
            hold_cnt <= '0;
        end else begin
            state <= state_nx;
            if (capture) begin
                hold_cnt <= holdoff;
            end else if (state == ST_HOLD) begin
                hold_cnt <= hold_cnt - DATA_W'(1);
            end
        end
    end

    // outputs: pulse plus latched identity and parameter set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            det_id      <= '0;
            pkt_len     <= '0;
            sym_size    <= '0;
            train_len   <= '0;
        end else begin
            frame_start <= capture;
            if (capture) begin
                det_id    <= win_id;
                pkt_len   <= par_flat[sel_base + FLD_PKT*DATA_W +: DATA_W];
                sym_size  <= par_flat[sel_base + FLD_SYM*DATA_W +: DATA_W];
                train_len <= par_flat[sel_base + FLD_TRN*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/psa_chk.sv
module psa_chk
    import psa_pkg::*;
#(
    parameter int                NUM_CH    = 3,
    parameter int                ID_W      = 2,
    parameter int                DATA_W    = 16,
    parameter logic [NUM_CH-1:0] LONG_MASK = 3'b110
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] hit,
    input psa_state_t        st,
    input logic              frame_start,
    input logic [ID_W-1:0]   det_id,
    input logic [DATA_W-1:0] pkt_len,
    input logic [DATA_W-1:0] sym_size,
    input logic [DATA_W-1:0] train_len
);

    assert_pulse_from_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ((($past(hit) >> det_id) & NUM_CH'(1)) != '0));

    assert_long_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (($past(hit) & LONG_MASK) != '0)) |-> (((LONG_MASK >> det_id) & NUM_CH'(1)) != '0));

    assert_id_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (int'(det_id) < NUM_CH));

    assert_no_pulse_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HOLD) && ($past(st) == ST_HOLD)) |-> !frame_start);

    assert_outputs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> ($stable(det_id) && $stable(pkt_len) && $stable(sym_size) && $stable(train_len)));

endmodule

bind preamble_std_arbiter psa_chk #(
    .NUM_CH   (NUM_CH),
    .ID_W     (ID_W),
    .DATA_W   (DATA_W),
    .LONG_MASK(LONG_MASK)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .st         (state),
    .frame_start(frame_start),
    .det_id     (det_id),
    .pkt_len    (pkt_len),
    .sym_size   (sym_size),
    .train_len  (train_len)
);

// File: tb/preamble_std_arbiter_tb_top.sv
`timescale 1ns/1ps
module preamble_std_arbiter_tb_top;

    localparam int N_VEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  met_valid = '0;
    logic [23:0] met_data = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        frame_start;
    logic [1:0]  det_id;
    logic [15:0] pkt_len, sym_size, train_len;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    preamble_std_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .met_valid(met_valid), .met_data(met_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .det_id(det_id), .pkt_len(pkt_len),
        .sym_size(sym_size), .train_len(train_len)
    );

    // {m0, m1, m2, valid[2:0], fire, id}
    localparam logic [29:0] VEC [N_VEC] = '{
        {8'd51,  8'd0,   8'd0,   3'b001, 1'b1, 2'd0},
        {8'd50,  8'd0,   8'd0,   3'b001, 1'b0, 2'd0},
        {8'd0,   8'd101, 8'd0,   3'b010, 1'b1, 2'd1},
        {8'd0,   8'd100, 8'd101, 3'b110, 1'b1, 2'd2},
        {8'd200, 8'd101, 8'd0,   3'b011, 1'b1, 2'd1},
        {8'd200, 8'd0,   8'd101, 3'b101, 1'b1, 2'd2},
        {8'd0,   8'd120, 8'd120, 3'b110, 1'b1, 2'd1},
        {8'd60,  8'd120, 8'd120, 3'b111, 1'b1, 2'd1},
        {8'd255, 8'd255, 8'd255, 3'b000, 1'b0, 2'd0},
        {8'd90,  8'd101, 8'd0,   3'b001, 1'b1, 2'd0},
        {8'd0,   8'd0,   8'd0,   3'b111, 1'b0, 2'd0},
        {8'd49,  8'd0,   8'd100, 3'b101, 1'b0, 2'd0}
    };
    string vec_req [N_VEC] = '{"R2", "R2", "R5", "R2", "R3", "R3",
                                "R4", "R4", "R2", "R2", "R2", "R2"};

    function automatic logic [15:0] exp_par(input int k, input int f);
        return 16'(256 * (f + 1) + k);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(addr);
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic drive(input int m0, input int m1, input int m2, input logic [2:0] v);
        met_data  = {8'(m2), 8'(m1), 8'(m0)};
        met_valid = v;
        @(negedge clk);
    endtask

    task automatic check_params(input string tag, input int k);
        check({tag, " det_id"}, int'(det_id), k);
        check({tag, " pkt_len"}, int'(pkt_len), int'(exp_par(k, 0)));
        check({tag, " sym_size"}, int'(sym_size), int'(exp_par(k, 1)));
        check({tag, " train_len"}, int'(train_len), int'(exp_par(k, 2)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 frame_start in reset", int'(frame_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 frame_start after reset", int'(frame_start), 0);
        check("R1 det_id after reset", int'(det_id), 0);
        check("R1 params after reset", int'(pkt_len | sym_size | train_len), 0);

        // R8: load the parameter sets through the map 4+3k+f
        for (int k = 0; k < 3; k++) begin
            for (int f = 0; f < 3; f++) begin
                cfg_write(4 + 3 * k + f, int'(exp_par(k, f)));
            end
        end

        // table walk with default thresholds (R1) and hold-off 0
        for (int i = 0; i < N_VEC; i++) begin
            logic [29:0] v;
            v = VEC[i];
            drive(int'(v[29:22]), int'(v[21:14]), int'(v[13:6]), v[5:3]);
            check({vec_req[i], " table frame_start"}, int'(frame_start), int'(v[2]));
            if (v[2]) check_params({vec_req[i], " R5 table"}, int'(v[1:0]));
        end
        drive(0, 0, 0, 3'b000);
        check("R5 pulse one cycle", int'(frame_start), 0);

        // R8: programmable threshold, strict comparison
        cfg_write(0, 20);
        drive(21, 0, 0, 3'b001);
        check("R8 thr write above", int'(frame_start), 1);
        drive(20, 0, 0, 3'b001);
        check("R8 thr write equal", int'(frame_start), 0);
        cfg_write(0, 50);

        // R6: hold-off of three edges
        cfg_write(3, 3);
        for (int s = 0; s < 5; s++) begin
            drive(51, 0, 0, 3'b001);
            check($sformatf("R6 holdoff edge %0d", s), int'(frame_start), (s == 0 || s == 4) ? 1 : 0);
        end
        drive(0, 0, 0, 3'b000);
        repeat (4) @(negedge clk);
        cfg_write(3, 0);

        // R6: zero hold-off, back-to-back detections
        drive(0, 101, 0, 3'b010);
        check("R6 zero holdoff first", int'(frame_start), 1);
        drive(51, 0, 0, 3'b001);
        check("R6 zero holdoff second", int'(frame_start), 1);
        check("R6 zero holdoff id", int'(det_id), 0);

        // R7: parameter rewrite does not reach outputs until next detection
        drive(0, 101, 0, 3'b010);
        check_params("R7 before rewrite", 1);
        met_valid = 3'b000;
        cfg_write(4 + 3 * 1 + 0, 16'hABCD);
        drive(0, 0, 0, 3'b000);
        check("R7 pkt_len held", int'(pkt_len), int'(exp_par(1, 0)));
        check("R7 no pulse", int'(frame_start), 0);
        drive(0, 101, 0, 3'b010);
        check("R7 pkt_len updated", int'(pkt_len), 16'hABCD);
        drive(0, 0, 0, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule